// File: doc/BRIEF.md
# Divider-Driven Programmable Timer

A byte-wide memory-mapped timer that runs on the machine clock. A free-running 16-bit divider advances by one on every cycle. An 8-bit counter steps whenever a chosen divider bit falls from 1 to 0, and a period select picks that bit. When the counter wraps past 0xFF it reads zero for a short delay. It is then loaded from a reload register and raises a single-cycle interrupt request. A second single-cycle pulse marks each fall of divider bit 12. It paces an external audio frame sequencer.

Software reaches four byte registers over a simple bus: address, write enable, write data and combinational read data. Because the counter watches edges of the shared divider, any divider clear can itself step the counter or fire the audio pulse. During the reload delay, a write to the counter cancels the pending reload and its interrupt.

Top module: `divTimer`

## Requirements
- R1: Reads are combinational. Address 0 returns divider bits [15:8]. Address 1 returns the counter and address 2 returns the reload value. Address 3 returns the control bits [2:0] with bits [7:3] read as zero, and only control bits [2:0] are stored.
- R2: The divider adds one on every clock edge. A write to address 0 clears all 16 bits to zero, whatever the data.
- R3: Control bits [1:0] select the divider bit whose 1-to-0 transition steps the counter: 0 selects bit 9 (every 1024 cycles), 1 selects bit 3 (16), 2 selects bit 5 (64) and 3 selects bit 7 (256). The counter changes on the same edge as the divider.
- R4: With control bit 2 at 0, the counter does not step.
- R5: A divider clear that drops the selected bit from 1 to 0 steps the counter on that edge, just like a natural fall.
- R6: The counter can wrap from 0xFF to 0x00. It then reads 0x00 for four cycles. On the fourth edge after the wrap it takes the reload value, and the interrupt request is high for exactly the following cycle.
- R7: A write to the counter while a reload is pending cancels that reload and its interrupt request, and the written value is kept.
- R8: When a counter write and a counter step fall on the same edge, the written value wins.
- R9: When divider bit 12 falls from 1 to 0, including through a divider clear, the audio tick is high for exactly the following cycle.
- R10: Reset clears the divider, counter, reload and control registers and any pending reload, and it raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Machine clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 2 | Register byte address |
| busWe | input | 1 | Write strobe for the addressed register |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Combinational read data |
| timerIrq | output | 1 | One-cycle interrupt request after a reload |
| audioTick | output | 1 | One-cycle pulse on each fall of divider bit 12 |

## Verification
The hardest cases to reach are the four-cycle window after a wrap and a counter write that lands on the exact edge where the tapped bit falls. The ports give no view of the divider's low bits. The stimulus therefore clears the divider, then writes the counter one cycle later so that its phase is known. From there it counts cycles, so a wrap, a write inside the reload window or a write on the stepping edge lands on a known cycle. The same phase control sets up divider clears that occur while bit 3 or bit 12 is high, which checks steps and audio pulses caused by a clear.

// File: rtl/divtimer_pkg.sv
package divtimer_pkg;
  // strobes from the control unit to the datapath
  typedef struct packed {
    logic inc;     // tapped divider bit fell this cycle
    logic reload;  // load counter from reload register
  } tmrStrobe_t;
endpackage

// File: rtl/tmrDatapath.sv
module tmrDatapath
  import divtimer_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  tmrStrobe_t        strobe,
  output logic [DATA_W-1:0] busRdata,
  output logic [DIV_W-1:0]  divCur,
  output logic [DIV_W-1:0]  divNext,
  output logic [DATA_W-1:0] counterVal,
  output logic [2:0]        ctrlVal,
  output logic              cntWrite
);
  logic [DATA_W-1:0] reloadReg;
  logic              divClear;

  assign divClear = busWe && (busAddr == 2'd0);
  assign cntWrite = busWe && (busAddr == 2'd1);
  assign divNext  = divClear ? '0 : divCur + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCur     <= '0;
      counterVal <= '0;
      reloadReg  <= '0;
      ctrlVal    <= '0;
    end else begin
      divCur <= divNext;
      if (cntWrite)           counterVal <= busWdata;
      else if (strobe.reload) counterVal <= reloadReg;
      else if (strobe.inc)    counterVal <= counterVal + 1'b1;
      if (busWe && busAddr == 2'd2) reloadReg <= busWdata;
      if (busWe && busAddr == 2'd3) ctrlVal   <= busWdata[2:0];
    end
  end

  always_comb begin
    case (busAddr)
      2'd0:    busRdata = divCur[DIV_W-1 -: DATA_W];
      2'd1:    busRdata = counterVal;
      2'd2:    busRdata = reloadReg;
      default: busRdata = {{(DATA_W-3){1'b0}}, ctrlVal};
    endcase
  end

  assert_div_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    divClear |=> (divCur == '0));

  assert_ctrl_pad_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd3) |-> (busRdata[DATA_W-1:3] == '0));

  assert_hold_disabled_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlVal[2] && !cntWrite && !strobe.reload) |=> $stable(counterVal));
endmodule

// File: rtl/tmrControl.sv
module tmrControl
  import divtimer_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int DATA_W    = 8,
  parameter int DELAY     = 4,
  parameter int AUDIO_BIT = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divCur,
  input  logic [DIV_W-1:0]  divNext,
  input  logic [2:0]        ctrlVal,
  input  logic [DATA_W-1:0] counterVal,
  input  logic              cntWrite,
  output tmrStrobe_t        strobe,
  output logic              timerIrq,
  output logic              audioTick
);
  localparam int TAP_W = $clog2(DIV_W);
  localparam int DLY_W = (DELAY > 1) ? $clog2(DELAY) : 1;

  function automatic logic [TAP_W-1:0] tapOf(input logic [1:0] sel);
    case (sel)
      2'd0:    return TAP_W'(9);
      2'd1:    return TAP_W'(3);
      2'd2:    return TAP_W'(5);
      default: return TAP_W'(7);
    endcase
  endfunction

  logic [TAP_W-1:0] tapSel;
  logic             tapFall, audioFall, overflow, reloadNow, pending;
  logic [DLY_W-1:0] delayCnt;

  assign tapSel    = tapOf(ctrlVal[1:0]);
  assign tapFall   = ctrlVal[2] && divCur[tapSel] && !divNext[tapSel];
  assign audioFall = divCur[AUDIO_BIT] && !divNext[AUDIO_BIT];
  assign reloadNow = pending && (delayCnt == '0) && (counterVal == '0) && !cntWrite;
  assign overflow  = tapFall && (counterVal == '1) && !cntWrite && !reloadNow;

  assign strobe.inc    = tapFall;
  assign strobe.reload = reloadNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending   <= 1'b0;
      delayCnt  <= '0;
      timerIrq  <= 1'b0;
      audioTick <= 1'b0;
    end else begin
      timerIrq  <= reloadNow;
      audioTick <= audioFall;
      if (overflow) begin
        pending  <= 1'b1;
        delayCnt <= DLY_W'(DELAY - 1);
      end else if (pending) begin
        if (cntWrite || counterVal != '0 || delayCnt == '0) pending <= 1'b0;
        else delayCnt <= delayCnt - 1'b1;
      end
    end
  end

  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    timerIrq |=> !timerIrq);

  assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> (counterVal == '0));

  assert_cancel_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pending && cntWrite) |=> (!pending && !timerIrq));

  assert_audio_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    audioTick |=> !audioTick);
endmodule

// File: rtl/divTimer.sv
module divTimer
  import divtimer_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int DATA_W    = 8,
  parameter int DELAY     = 4,
  parameter int AUDIO_BIT = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              timerIrq,
  output logic              audioTick
);
  tmrStrobe_t        strobe;
  logic [DIV_W-1:0]  divCur, divNext;
  logic [DATA_W-1:0] counterVal;
  logic [2:0]        ctrlVal;
  logic              cntWrite;

  tmrDatapath #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .strobe(strobe), .busRdata(busRdata),
    .divCur(divCur), .divNext(divNext), .counterVal(counterVal),
    .ctrlVal(ctrlVal), .cntWrite(cntWrite)
  );

  tmrControl #(.DIV_W(DIV_W), .DATA_W(DATA_W), .DELAY(DELAY),
               .AUDIO_BIT(AUDIO_BIT)) u_ctl (
    .clk(clk), .rstN(rstN), .divCur(divCur), .divNext(divNext),
    .ctrlVal(ctrlVal), .counterVal(counterVal), .cntWrite(cntWrite),
    .strobe(strobe), .timerIrq(timerIrq), .audioTick(audioTick)
  );
endmodule

// File: tb/divTimer_tb.sv
module divTimer_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       timerIrq, audioTick;
  int checks = 0;
  int fails = 0;

  divTimer u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .timerIrq(timerIrq),
    .audioTick(audioTick)
  );

  always #5 clk = ~clk;

  // {address, write data, expected readback}
  localparam logic [17:0] VECS [7] = '{
    {2'd1, 8'h5A, 8'h5A}, {2'd2, 8'hC3, 8'hC3}, {2'd3, 8'hFF, 8'h07},
    {2'd3, 8'h05, 8'h05}, {2'd3, 8'h02, 8'h02}, {2'd1, 8'h00, 8'h00},
    {2'd2, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [7:0] v;
    logic irqSeen;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R10 reset reg", {8'h0, v}, 16'h0);
    end
    chk("R10 irq idle", {15'h0, timerIrq}, 16'h0);

    // R1: register access table
    for (int i = 0; i < 7; i++) begin
      wr(VECS[i][17:16], VECS[i][15:8]);
      rd(VECS[i][17:16], v);
      chk("R1 readback", {8'h0, v}, {8'h0, VECS[i][7:0]});
    end

    // R2: divider clear and count
    wr(2'd0, 8'hFF);
    rd(2'd0, v);
    chk("R2 divider cleared", {8'h0, v}, 16'h0);
    repeat (16'h1234) @(negedge clk);
    rd(2'd0, v);
    chk("R2 divider count", {8'h0, v}, 16'h12);

    // R3: period selects
    for (int s = 0; s < 4; s++) begin
      int m, e;
      case (s)
        0: begin m = 2100; e = 2; end
        1: begin m = 40;   e = 2; end
        2: begin m = 200;  e = 3; end
        default: begin m = 600; e = 2; end
      endcase
      wr(2'd3, {5'b0, 1'b1, 2'(s)});
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h00);
      repeat (m - 1) @(negedge clk);
      rd(2'd1, v);
      chk("R3 step rate", {8'h0, v}, 16'(e));
    end

    // R4: disabled counter holds
    wr(2'd3, 8'h01);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    repeat (100) @(negedge clk);
    rd(2'd1, v);
    chk("R4 disabled hold", {8'h0, v}, 16'h0);

    // R5: divider clear while bit 3 high steps counter
    wr(2'd3, 8'h05);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h10);
    repeat (7) @(negedge clk);
    wr(2'd0, 8'h00);
    rd(2'd1, v);
    chk("R5 clear step", {8'h0, v}, 16'h11);

    // R6: wrap, delay, reload, interrupt
    wr(2'd2, 8'hA0);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hFF);
    repeat (14) @(negedge clk);
    rd(2'd1, v);
    chk("R6 before wrap", {8'h0, v}, 16'hFF);
    @(negedge clk);
    rd(2'd1, v);
    chk("R6 wrap zero", {8'h0, v}, 16'h0);
    chk("R6 no early irq", {15'h0, timerIrq}, 16'h0);
    repeat (3) @(negedge clk);
    rd(2'd1, v);
    chk("R6 zero last cycle", {8'h0, v}, 16'h0);
    chk("R6 irq not yet", {15'h0, timerIrq}, 16'h0);
    @(negedge clk);
    rd(2'd1, v);
    chk("R6 reloaded", {8'h0, v}, 16'hA0);
    chk("R6 irq high", {15'h0, timerIrq}, 16'h1);
    @(negedge clk);
    chk("R6 irq one cycle", {15'h0, timerIrq}, 16'h0);

    // R7: write during delay cancels
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hFF);
    repeat (16) @(negedge clk);
    rd(2'd1, v);
    chk("R7 pending zero", {8'h0, v}, 16'h0);
    wr(2'd1, 8'h33);
    irqSeen = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (timerIrq) irqSeen = 1'b1;
    end
    rd(2'd1, v);
    chk("R7 written kept", {8'h0, v}, 16'h33);
    chk("R7 irq cancelled", {15'h0, irqSeen}, 16'h0);

    // R8: write beats step on the same edge
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h40);
    repeat (14) @(negedge clk);
    wr(2'd1, 8'h77);
    rd(2'd1, v);
    chk("R8 write priority", {8'h0, v}, 16'h77);

    // R9: audio tick, natural and from a clear
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h00);
    repeat (8191) @(negedge clk);
    chk("R9 tick before", {15'h0, audioTick}, 16'h0);
    @(negedge clk);
    chk("R9 tick natural", {15'h0, audioTick}, 16'h1);
    @(negedge clk);
    chk("R9 tick one cycle", {15'h0, audioTick}, 16'h0);
    repeat (4095) @(negedge clk);
    wr(2'd0, 8'hAA);
    chk("R9 tick from clear", {15'h0, audioTick}, 16'h1);
    @(negedge clk);
    chk("R9 tick clear ends", {15'h0, audioTick}, 16'h0);

    // R10: reset during a pending reload
    wr(2'd3, 8'h05);
    wr(2'd2, 8'h55);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hFF);
    repeat (15) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    for (int a = 1; a < 4; a++) begin
      rd(2'(a), v);
      chk("R10 reset clears", {8'h0, v}, 16'h0);
    end
    rstN = 1'b1;
    irqSeen = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (timerIrq) irqSeen = 1'b1;
    end
    chk("R10 no irq after reset", {15'h0, irqSeen}, 16'h0);
    rd(2'd1, v);
    chk("R10 counter stays", {8'h0, v}, 16'h0);

    finishRun();
  end
endmodule